// File: doc/BRIEF.md
# One-Bit Circular Delay Line Sequencer for Dynamic RAM

This block turns a one-bit-wide dynamic RAM into a circular delay line for a delta-modulated audio stream. A sample tick from the modulator clock starts each slot. On that tick the block latches the comparator bit. It reads the oldest bit stored at the current address and presents it as the delayed output. It then writes the new bit into the same cell and moves the address on by one. All accesses take their address from one counter. Its low half goes out on the multiplexed address bus while RAS is low, and its high half while CAS is low. Because consecutive samples land in consecutive rows, the normal run of samples also keeps the memory refreshed.

The delay is the number of addresses in use times the sample period. Software-free control comes from a `last_addr` input, which names the highest address in the loop. A larger value takes effect only when the counter next wraps. A smaller value cuts the loop short at once: the counter returns to zero at its next step if it is already at or past the new end. A monitor raises a sticky `refresh_err` if sample ticks come too far apart for every used row to be revisited within the refresh budget.

The sequencer has eight states. `S_IDLE` waits for a tick. `S_RD_ROW` drives the row with RAS low. `S_RD_COL` drives the column with CAS low. `S_RD_CAP` captures the read data. `S_PRE` releases all strobes. `S_WR_ROW` drives the row with RAS and WE low. `S_WR_COL` drives the column with CAS low and WE still low. `S_WR_END` releases the strobes and steps the counter. The transitions run idle→rd_row on a tick. Every other state moves to the next one in the order just given, and `S_WR_END` returns to idle.

Top module: `dram_delay_seq`

## Requirements
- R1: While reset is asserted and after it is released, the counter is zero, `ram_ras_n`, `ram_cas_n` and `ram_we_n` are all 1, `dly_bit` is 0 and `refresh_err` is 0.
- R2: A tick seen in `S_IDLE` latches `sample_bit` and starts an eight-cycle slot. A tick seen while a slot is running is ignored: it neither latches data nor moves the counter.
- R3: The read cycle drives the row on `ram_addr` with only RAS low, then the column with RAS and CAS low and WE high. The row is address bits [HALF_W-1:0] and the column is bits [2*HALF_W-1:HALF_W]. CAS is never low unless RAS is low.
- R4: The write cycle uses the same address as the read in that slot. It drives the row with RAS and WE low, then the column with CAS also low, and `ram_d` carries the latched sample.
- R5: `dly_bit` changes only at the end of `S_RD_CAP`, where it takes `ram_q`. It holds its value for the rest of the sample period.
- R6: After each write the counter steps up by one. It returns to 0 when it reaches the active end. With a fixed `last_addr` = N, each output bit is the sample taken N+1 ticks earlier.
- R7: A larger `last_addr` is adopted only at the next wrap. If the counter is at or beyond a new, smaller `last_addr` when it steps, it returns to 0.
- R8: `refresh_err` is set once GAP_LIMIT = REFRESH_CYC/(2·2^HALF_W) clocks pass without a tick. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample tick, one clock wide |
| sample_bit | input | 1 | Comparator bit from the modulator |
| last_addr | input | 2*HALF_W | Highest address used by the loop |
| dly_bit | output | 1 | Delayed bit toward the output integrator |
| ram_addr | output | HALF_W | Multiplexed row/column address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_d | output | 1 | Data to the memory |
| ram_q | input | 1 | Data from the memory |
| refresh_err | output | 1 | Sticky refresh-budget violation |

## Verification
The bench builds the block with HALF_W = 2, which gives a 16-cell memory of four rows, and REFRESH_CYC = 256, which gives a gap limit of 32 clocks. With 16 cells, a six-cell loop fills and echoes within a dozen ticks. The same size also lets the bench show a growth of the loop waiting for the wrap and a shrink taking effect at once, and its model RAM keeps the whole array. The 32-clock limit sits above the 10-clock tick spacing, so normal traffic leaves the flag clear. A pause of a few dozen clocks is enough to set it.

// File: rtl/dds_pkg.sv
package dds_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ROW,
        S_RD_COL,
        S_RD_CAP,
        S_PRE,
        S_WR_ROW,
        S_WR_COL,
        S_WR_END
    } seq_state_t;

endpackage

// File: rtl/dds_fsm.sv
module dds_fsm
    import dds_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic start,
    output logic cap,
    output logic adv,
    output logic sel_col,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);

    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (tick) state_nx = S_RD_ROW;
            S_RD_ROW: state_nx = S_RD_COL;
            S_RD_COL: state_nx = S_RD_CAP;
            S_RD_CAP: state_nx = S_PRE;
            S_PRE:    state_nx = S_WR_ROW;
            S_WR_ROW: state_nx = S_WR_COL;
            S_WR_COL: state_nx = S_WR_END;
            S_WR_END: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        start   = 1'b0;
        cap     = 1'b0;
        adv     = 1'b0;
        sel_col = 1'b0;
        ras_n   = 1'b1;
        cas_n   = 1'b1;
        we_n    = 1'b1;
        unique case (state)
            S_IDLE:   start = tick;
            S_RD_ROW: ras_n = 1'b0;
            S_RD_COL: begin ras_n = 1'b0; cas_n = 1'b0; sel_col = 1'b1; end
            S_RD_CAP: begin ras_n = 1'b0; cas_n = 1'b0; sel_col = 1'b1; cap = 1'b1; end
            S_PRE:    ;
            S_WR_ROW: begin ras_n = 1'b0; we_n = 1'b0; end
            S_WR_COL: begin ras_n = 1'b0; cas_n = 1'b0; we_n = 1'b0; sel_col = 1'b1; end
            S_WR_END: adv = 1'b1;
        endcase
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R3
    AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) && !we_n |-> $past(!we_n)); // R4

endmodule

// File: rtl/dds_addr.sv
module dds_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [ADDR_W-1:0] last_addr,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] lim;
    logic              wrap;

    assign wrap = (addr >= lim) || (addr >= last_addr);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            lim  <= '1;
        end else if (adv) begin
            if (wrap) begin
                addr <= '0;
                lim  <= last_addr;
            end else begin
                addr <= addr + 1'b1;
            end
        end
    end

    AST_ADDR_IN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        addr <= lim); // R6
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (addr == $past(addr) + 1'b1) || (addr == '0)); // R6
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(addr)); // R2

endmodule

// File: rtl/dds_refresh.sv
module dds_refresh #(
    parameter int GAP_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic err
);

    localparam int CNT_W = $clog2(GAP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(GAP_LIMIT);

    logic [CNT_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
            err <= 1'b0;
        end else begin
            if (tick)              gap <= '0;
            else if (gap != LIMIT) gap <= gap + 1'b1;
            if (gap == LIMIT)      err <= 1'b1;
        end
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R8

endmodule

// File: rtl/dram_delay_seq.sv
module dram_delay_seq #(
    parameter int HALF_W      = 8,
    parameter int REFRESH_CYC = 65536
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sample_bit,
    input  logic [2*HALF_W-1:0] last_addr,
    output logic                dly_bit,
    output logic [HALF_W-1:0]   ram_addr,
    output logic                ram_ras_n,
    output logic                ram_cas_n,
    output logic                ram_we_n,
    output logic                ram_d,
    input  logic                ram_q,
    output logic                refresh_err
);

    localparam int ADDR_W    = 2 * HALF_W;
    localparam int ROWS      = 1 << HALF_W;
    localparam int GAP_LIMIT = REFRESH_CYC / (2 * ROWS);

    logic              start, cap, adv, sel_col;
    logic [ADDR_W-1:0] addr;
    logic              sample_q;

    dds_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .start   (start),
        .cap     (cap),
        .adv     (adv),
        .sel_col (sel_col),
        .ras_n   (ram_ras_n),
        .cas_n   (ram_cas_n),
        .we_n    (ram_we_n)
    );

    dds_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .last_addr (last_addr),
        .addr      (addr)
    );

    dds_refresh #(.GAP_LIMIT(GAP_LIMIT)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .err   (refresh_err)
    );

    assign ram_addr = sel_col ? addr[ADDR_W-1:HALF_W] : addr[HALF_W-1:0];
    assign ram_d    = sample_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            dly_bit  <= 1'b0;
        end else begin
            if (start) sample_q <= sample_bit;
            if (cap)   dly_bit  <= ram_q;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(dly_bit)); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ram_ras_n && ram_cas_n && ram_we_n); // R1

endmodule

// File: tb/dram_delay_seq_bench.sv
`timescale 1ns/1ps
module dram_delay_seq_bench;

    localparam int HW = 2;
    localparam int AW = 2 * HW;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic sample_bit = 1'b0;
    logic [AW-1:0] last_addr = AW'(5);
    logic dly_bit, ram_ras_n, ram_cas_n, ram_we_n, ram_d, ram_q, refresh_err;
    logic [HW-1:0] ram_addr;

    always #2.5 clk = ~clk;

    dram_delay_seq #(.HALF_W(HW), .REFRESH_CYC(256)) u_dram_delay_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sample_bit(sample_bit),
        .last_addr(last_addr), .dly_bit(dly_bit), .ram_addr(ram_addr),
        .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
        .ram_d(ram_d), .ram_q(ram_q), .refresh_err(refresh_err)
    );

    // memory model: latch row/col shortly after each strobe falls
    logic mem [1<<AW];
    logic [HW-1:0] row_l = '0, col_l = '0;
    initial for (int i = 0; i < (1<<AW); i++) mem[i] = 1'b0;
    always @(negedge ram_ras_n) #1 row_l = ram_addr;
    always @(negedge ram_cas_n) begin
        #1 col_l = ram_addr;
        if (!ram_we_n) mem[{col_l, row_l}] = ram_d;
    end
    assign ram_q = (!ram_cas_n && ram_we_n) ? mem[{col_l, row_l}] : 1'b0;

    int runs = 0, fails = 0;

    task automatic check(input string req, input int act, input int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference delay line
    logic ref_mem [1<<AW];
    int ref_addr = 0;
    int ref_lim = (1<<AW) - 1;
    initial for (int i = 0; i < (1<<AW); i++) ref_mem[i] = 1'b0;

    function automatic int ref_step(input logic s, input int last);
        int o;
        o = ref_mem[ref_addr];
        ref_mem[ref_addr] = s;
        if (ref_addr >= ref_lim || ref_addr >= last) begin
            ref_addr = 0;
            ref_lim = last;
        end else ref_addr++;
        return o;
    endfunction

    // one sample slot, ten clocks, starting at a negedge
    task automatic slot(input logic s);
        sample_bit = s;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    // {last_addr, sample}
    localparam logic [AW:0] VEC [NV] = '{
        {4'd5,1'b1},{4'd5,1'b0},{4'd5,1'b1},{4'd5,1'b1},{4'd5,1'b0},
        {4'd5,1'b0},{4'd5,1'b1},{4'd5,1'b0},{4'd5,1'b1},{4'd5,1'b1},
        {4'd9,1'b1},{4'd9,1'b0},{4'd9,1'b0},{4'd9,1'b1},{4'd9,1'b1},
        {4'd2,1'b0},{4'd2,1'b1},{4'd2,1'b1},{4'd2,1'b0},{4'd2,1'b1}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        runs++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin : main
        int e;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 ras", ram_ras_n, 1);
        check("R1 cas", ram_cas_n, 1);
        check("R1 we", ram_we_n, 1);
        check("R1 dly", dly_bit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 err", refresh_err, 0);
        check("R1 dly after release", dly_bit, 0);

        // R6/R7: table walk against the reference delay line
        for (int i = 0; i < NV; i++) begin
            last_addr = VEC[i][AW:1];
            e = ref_step(VEC[i][0], int'(VEC[i][AW:1]));
            slot(VEC[i][0]);
            check($sformatf("R6/R7 vec%0d", i), dly_bit, e);
        end
        check("R8 no err under steady ticks", refresh_err, 0);

        // R3/R4: strobe and address sequence for one slot
        last_addr = AW'(9);
        sample_bit = 1'b1;
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;            // S_RD_ROW
        check("R3 rd_row ras", ram_ras_n, 0);
        check("R3 rd_row cas", ram_cas_n, 1);
        check("R3 rd_row addr", ram_addr, ref_addr % (1<<HW));
        @(negedge clk);                          // S_RD_COL
        check("R3 rd_col cas", ram_cas_n, 0);
        check("R3 rd_col we", ram_we_n, 1);
        check("R3 rd_col addr", ram_addr, ref_addr / (1<<HW));
        e = ref_step(1'b1, 9);
        @(negedge clk);                          // S_RD_CAP
        @(negedge clk);                          // S_PRE
        check("R5 dly after capture", dly_bit, e);
        check("R4 pre strobes", ram_ras_n & ram_cas_n & ram_we_n, 1);
        @(negedge clk);                          // S_WR_ROW
        check("R4 wr_row we", ram_we_n, 0);
        check("R4 wr_row cas", ram_cas_n, 1);
        @(negedge clk);                          // S_WR_COL
        check("R4 wr_col cas", ram_cas_n, 0);
        check("R4 wr_col d", ram_d, 1);
        @(negedge clk);                          // S_WR_END
        check("R5 dly held", dly_bit, e);
        repeat (3) @(negedge clk);

        // R2: tick during a busy slot is ignored
        sample_bit = 1'b0;
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        @(negedge clk); @(negedge clk);
        sample_bit = 1'b1;
        tick = 1'b1;                             // lands in S_RD_CAP
        @(negedge clk); tick = 1'b0;
        repeat (7) @(negedge clk);
        e = ref_step(1'b0, 9);
        check("R2 no extra slot", ram_ras_n, 1);
        tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        check("R2 counter stepped once", ram_addr, ref_addr % (1<<HW));
        repeat (9) @(negedge clk);
        void'(ref_step(1'b1, 9));

        // R8: starve the tick, then confirm stickiness and reset clear
        repeat (40) @(negedge clk);
        check("R8 err set", refresh_err, 1);
        slot(1'b0);
        check("R8 err sticky", refresh_err, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8/R1 err cleared by reset", refresh_err, 0);
        check("R1 dly cleared by reset", dly_bit, 0);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

endmodule